// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the register front end of a single DMA channel that serves one attached peripheral. Software reaches it through a plain 32-bit register bus with an address, a write strobe, a read strobe and write data. Read data comes back on a registered output. The channel keeps four 32-bit words: a control/status word, the DMA address word, one general storage word and an address-extension word.

The control word does more than store what is written. Its top nibble always reads back as a fixed version code. A drain flag is set or cleared depending on the written value. A write to the address word raises a loaded flag inside the control word. Writing the control word with the interrupt enable clear drops the interrupt line at once. Setting the reset flag in a control write sends a one-cycle reset pulse to the peripheral. The peripheral raises and clears its interrupt through two strobes, and the block keeps a status copy of that interrupt in bit 0 of the control word.

Toward the transfer engine, the block ORs the extension word into every requested memory address. It also exposes the transfer direction flag.

Top module: `dma_ctl_regfile`

## Requirements
- R1: The word index is bus address bits [3:2] (0 control, 1 DMA address, 2 storage, 3 address extension). All other address bits are ignored for both reads and writes.
- R2: After reset the control word reads 0xA0000000, the other three words read 0, and `irq_out` and `dev_rst_pulse` are 0.
- R3: A control-word write stores bits [27:0] of the adjusted write value and forces bits [31:28] to 0xA.
- R4: A control-word write whose bit 4 (interrupt enable) is 0 makes `irq_out` 0 on the next cycle, unless `irq_set` is high in the same cycle.
- R5: A control-word write with bit 7 set makes `dev_rst_pulse` high for exactly the one cycle after the write. That value is stored unmodified apart from the version nibble.
- R6: In a control-word write with bit 7 clear and bit 6 set, bit 6 is stored as 0. A write of exactly zero is stored as 0xA0000040.
- R7: A write to word 1 stores the write data and also sets bit 26 (loaded) of the control word.
- R8: `irq_set` sets control bit 0 and makes `irq_out` 1 on the next cycle. `irq_clr` clears both. `irq_set` wins over `irq_clr` and over a same-cycle control write. `irq_clr` wins over the bit 0 value of a same-cycle control write.
- R9: `xfer_mem_addr` equals `xfer_req_addr` bitwise-ORed with word 3, with no register in the path. `xfer_to_mem` equals control bit 8 (1 = write to memory).
- R10: `bus_rdata` loads, at the clock edge of a cycle with `bus_rd` high, the value the addressed word held before that edge, and holds it otherwise. Words 2 and 3 store whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_set | input | 1 | Peripheral interrupt raise strobe |
| irq_clr | input | 1 | Peripheral interrupt clear strobe |
| irq_out | output | 1 | Interrupt request |
| dev_rst_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| xfer_req_addr | input | 32 | Memory address requested by the transfer engine |
| xfer_mem_addr | output | 32 | Requested address ORed with the extension word |
| xfer_to_mem | output | 1 | Transfer direction, 1 = write to memory |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together, so exactly one word is addressed per cycle. They also assume that strobes held through reset have no effect. The random stimulus picks a write, a read or an idle cycle as one exclusive choice, and it keeps every strobe low while reset is asserted. Interrupt strobes are drawn independently of the bus operation. This means set/clear collisions and collisions with control writes do occur, and the priority rules are exercised.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_CNT  = 4;
  localparam int IDX_W    = $clog2(REG_CNT);
  localparam logic [3:0] VER_CODE = 4'hA;
  localparam int B_IRQ    = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_RST    = 7;
  localparam int B_DIR    = 8;
  localparam int B_LOADED = 26;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dma_ctl_word.sv
module dma_ctl_word
  import dma_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  ld_set,
  input  word_t wdata,
  input  logic  irq_set,
  input  logic  irq_clr,
  output word_t ctl_q,
  output logic  irq_q,
  output logic  rst_pulse_q
);
  word_t wval;
  word_t ctl_nxt;
  logic  irq_nxt;

  always_comb begin
    wval = wdata;
    if (!wdata[B_RST]) begin
      if (wdata[B_DRAIN])    wval[B_DRAIN] = 1'b0;
      else if (wdata == '0)  wval[B_DRAIN] = 1'b1;
    end
    wval[DATA_W-1:DATA_W-4] = VER_CODE;

    ctl_nxt = ctl_q;
    if (wr_en)  ctl_nxt = wval;
    if (ld_set) ctl_nxt[B_LOADED] = 1'b1;
    if (irq_set)      ctl_nxt[B_IRQ] = 1'b1;
    else if (irq_clr) ctl_nxt[B_IRQ] = 1'b0;

    irq_nxt = irq_q;
    if (wr_en && !wdata[B_IEN]) irq_nxt = 1'b0;
    if (irq_clr)                irq_nxt = 1'b0;
    if (irq_set)                irq_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= {VER_CODE, {(DATA_W-4){1'b0}}};
      irq_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      ctl_q       <= ctl_nxt;
      irq_q       <= irq_nxt;
      rst_pulse_q <= wr_en && wdata[B_RST];
    end
  end
endmodule

// File: rtl/dma_ctl_bank.sv
module dma_ctl_bank
  import dma_ctl_pkg::*;
#(
  parameter int NUM = REG_CNT - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            regs_q [NUM]
);
  for (genvar g = 0; g < NUM; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 regs_q[g] <= '0;
      else if (wr_en && idx == IDX_W'(g + 1))  regs_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/dma_ctl_rdport.sv
module dma_ctl_rdport
  import dma_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  word_t            words [REG_CNT],
  output word_t            rdata_q
);
  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= words[idx];
  end
endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_set,
  input  logic              irq_clr,
  output logic              irq_out,
  output logic              dev_rst_pulse,
  input  logic [31:0]       xfer_req_addr,
  output logic [31:0]       xfer_mem_addr,
  output logic              xfer_to_mem
);
  logic [IDX_W-1:0] idx;
  word_t            ctl_q;
  word_t            bank_q [REG_CNT-1];
  word_t            all_q  [REG_CNT];
  logic             unused_addr;

  assign idx         = bus_addr[IDX_W+1:2];
  assign unused_addr = ^{bus_addr[1:0], bus_addr[ADDR_W-1:IDX_W+2]};

  dma_ctl_word u_word (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bus_wr && idx == '0),
    .ld_set      (bus_wr && idx == IDX_W'(1)),
    .wdata       (bus_wdata),
    .irq_set     (irq_set),
    .irq_clr     (irq_clr),
    .ctl_q       (ctl_q),
    .irq_q       (irq_out),
    .rst_pulse_q (dev_rst_pulse)
  );

  dma_ctl_bank #(.NUM(REG_CNT-1)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .idx    (idx),
    .wdata  (bus_wdata),
    .regs_q (bank_q)
  );

  always_comb begin
    all_q[0] = ctl_q;
    for (int i = 1; i < REG_CNT; i++) all_q[i] = bank_q[i-1];
  end

  dma_ctl_rdport u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .idx     (idx),
    .words   (all_q),
    .rdata_q (bus_rdata)
  );

  assign xfer_mem_addr = xfer_req_addr | bank_q[REG_CNT-2];
  assign xfer_to_mem   = ctl_q[B_DIR];
endmodule

// File: rtl/dma_ctl_regfile_chk.sv
module dma_ctl_regfile_chk
  import dma_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] wr_idx,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             wd_ien,
  input logic             wd_rst,
  input logic [3:0]       rd_ver,
  input logic             irq_set,
  input logic             irq_clr,
  input logic             irq_out,
  input logic             dev_rst_pulse,
  input logic [31:0]      xfer_req_addr,
  input logic [31:0]      xfer_mem_addr,
  input logic             loaded
);
  AST_VER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd && wr_idx == '0 |=> rd_ver == VER_CODE); // R3
  AST_IEN_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_wr && wr_idx == '0 && !wd_ien && !irq_set |=> !irq_out); // R4
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_wr && wr_idx == '0 && wd_rst |=> dev_rst_pulse); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dev_rst_pulse |-> $past(bus_wr && wr_idx == '0 && wd_rst)); // R5
  AST_LOADED_SET: assert property (@(posedge clk) disable iff (rst)
    bus_wr && wr_idx == IDX_W'(1) |=> loaded); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> irq_out); // R8
  AST_IRQ_LOWER: assert property (@(posedge clk) disable iff (rst)
    irq_clr && !irq_set |=> !irq_out); // R8
  AST_ADDR_COVER: assert property (@(posedge clk) disable iff (rst)
    (xfer_mem_addr & xfer_req_addr) == xfer_req_addr); // R9
endmodule

bind dma_ctl_regfile dma_ctl_regfile_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_idx        (idx),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .wd_ien        (bus_wdata[4]),
  .wd_rst        (bus_wdata[7]),
  .rd_ver        (bus_rdata[31:28]),
  .irq_set       (irq_set),
  .irq_clr       (irq_clr),
  .irq_out       (irq_out),
  .dev_rst_pulse (dev_rst_pulse),
  .xfer_req_addr (xfer_req_addr),
  .xfer_mem_addr (xfer_mem_addr),
  .loaded        (ctl_q[26])
);

// File: tb/dma_ctl_regfile_bench.sv
module dma_ctl_regfile_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_set = 1'b0, irq_clr = 1'b0;
  logic          irq_out, dev_rst_pulse;
  logic [31:0]   xfer_req_addr = '0;
  logic [31:0]   xfer_mem_addr;
  logic          xfer_to_mem;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m [4];
  logic        m_irq;

  always #4 clk = ~clk;

  dma_ctl_regfile #(.ADDR_W(AW)) u_dma_ctl_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set), .irq_clr(irq_clr),
    .irq_out(irq_out), .dev_rst_pulse(dev_rst_pulse), .xfer_req_addr(xfer_req_addr),
    .xfer_mem_addr(xfer_mem_addr), .xfer_to_mem(xfer_to_mem)
  );

  function automatic logic [31:0] ctl_after_write(input logic [31:0] d);
    logic [31:0] v = d;
    if (!d[7]) begin
      if (d[6])          v[6] = 1'b0;
      else if (d == '0)  v[6] = 1'b1;
    end
    v[31:28] = 4'hA;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input bit s, input bit c,
                      input logic [31:0] req, input string tag);
    logic [1:0]  ix = a[3:2];
    logic [31:0] exp_rd;
    bit          exp_pulse;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    irq_set = s; irq_clr = c; xfer_req_addr = req;
    @(posedge clk);
    exp_rd    = rd ? m[ix] : bus_rdata;
    exp_pulse = wr && ix == 2'd0 && d[7];
    if (wr && ix == 2'd0) m[0] = ctl_after_write(d);
    if (wr && ix != 2'd0) m[ix] = d;
    if (wr && ix == 2'd1) m[0][26] = 1'b1;
    if (s)      m[0][0] = 1'b1;
    else if (c) m[0][0] = 1'b0;
    if (wr && ix == 2'd0 && !d[4]) m_irq = 1'b0;
    if (c) m_irq = 1'b0;
    if (s) m_irq = 1'b1;
    @(negedge clk);
    chk({tag, " R8 irq_out"}, {31'd0, irq_out}, {31'd0, m_irq});
    chk({tag, " R5 dev_rst_pulse"}, {31'd0, dev_rst_pulse}, {31'd0, exp_pulse});
    chk({tag, " R9 xfer_to_mem"}, {31'd0, xfer_to_mem}, {31'd0, m[0][8]});
    chk({tag, " R9 xfer_mem_addr"}, xfer_mem_addr, req | m[3]);
    chk({tag, " R10 bus_rdata"}, bus_rdata, exp_rd);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b1, a, '0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    int unsigned seed = 32'd20240517;
    void'($urandom(seed));
    m[0] = 32'hA000_0000; m[1] = '0; m[2] = '0; m[3] = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    chk("R2 irq_out reset", {31'd0, irq_out}, 32'd0);
    chk("R2 pulse reset", {31'd0, dev_rst_pulse}, 32'd0);
    for (int i = 0; i < 4; i++) rd(AW'(i * 4), "R2 reset word");

    // R1: upper address bits ignored
    wr(8'hF8, 32'h1234_5678, "R1 write word2 alias");
    rd(8'h08, "R1 read word2");
    wr(8'h5C, 32'h0000_0F00, "R1 write word3 alias");
    rd(8'hAC, "R1 read word3 alias");
    step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 32'h8000_0001, "R9 or extension");

    // R3, R6: control adjustments
    wr(8'h00, 32'hFFFF_FF3F, "R3 nibble forced");
    rd(8'h00, "R3 read control");
    wr(8'h00, 32'h0000_0000, "R6 zero write");
    rd(8'h00, "R6 read 0xA0000040");
    wr(8'h00, 32'h0000_0150, "R6 drain cleared");
    rd(8'h00, "R6 read drain cleared");

    // R5: reset pulse, value stored as written
    wr(8'h40, 32'h5000_00C0, "R5 reset write");
    idle("R5 pulse ends");
    rd(8'h00, "R5 read after reset write");

    // R7: loaded flag
    wr(8'h04, 32'hDEAD_BEEF, "R7 address write");
    rd(8'h04, "R7 read address");
    rd(8'h00, "R7 loaded bit");

    // R8, R4: interrupt gating and priority
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, '0, "R8 raise");
    rd(8'h00, "R8 status bit set");
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, '0, "R8 set beats clear");
    wr(8'h00, 32'h0000_0010, "R4 enable kept");
    wr(8'h00, 32'h0000_0001, "R4 enable cleared");
    step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, '0, "R8 raise again");
    step(1'b1, 1'b0, 8'h00, 32'h0000_0000, 1'b1, 1'b0, '0, "R8 set beats write");
    rd(8'h00, "R8 bit0 after collision");
    step(1'b1, 1'b0, 8'h00, 32'h0000_0011, 1'b0, 1'b1, '0, "R8 clear beats write");
    rd(8'h00, "R8 bit0 cleared");

    // R10: read data held while no read
    rd(8'h08, "R10 read word2");
    wr(8'h08, 32'h0BAD_F00D, "R10 held during write");
    idle("R10 held idle");
    rd(8'h08, "R10 new value");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned op = $urandom_range(0, 2);
      logic [31:0] d = $urandom;
      int unsigned k = $urandom_range(0, 7);
      if (k == 0) d = '0;
      else if (k == 1) d[7] = 1'b0;
      step(op == 0, op == 1, AW'($urandom), d, $urandom_range(0, 5) == 0,
           $urandom_range(0, 5) == 0, $urandom, "R10 random");
    end
    for (int i = 0; i < 4; i++) rd(AW'(i * 4), "R1 final word");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule